// File: doc/BRIEF.md
# Sixteen-Pin GPIO Bank with Edge Interrupts

This block is a bank of sixteen general-purpose pins that software reaches through a 16-bit register bus. Each pin is set up as an input or an output. Output pins drive a value from an output latch. Input pins are sampled on every clock. When an input pin sees the edge that its polarity bit selects, it can raise a sticky status bit, and the block gives one interrupt line to the rest of the chip.

The bus is a single-cycle access port. A register is selected by the byte offset on `bus_addr` (bits [1:0] zero, word index in the upper bits), `bus_size` gives the access width (0 = 8-bit, 1 = 16-bit, 2 = 32-bit), and read data comes back combinationally in the same cycle. The address decoder turns each access into one of eight named register selections:

- `SEL_DIN`: sampled inputs, offset 0x00, read-only.
- `SEL_DOUT`: output latch, offset 0x04.
- `SEL_DIR`: direction, offset 0x08.
- `SEL_EDGE`: edge polarity, offset 0x0C.
- `SEL_MASK`: interrupt mask, offset 0x10.
- `SEL_STAT`: status, offset 0x14, write-one-to-clear.
- `SEL_PCTL`: input read gate, offset 0x18.
- `SEL_NONE`: every other offset and every misaligned offset.

An access enters the register file only when it is 16 bits wide and its selection is not `SEL_NONE`. A write also needs a selection other than `SEL_DIN`.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset, the output latch, direction, edge polarity, mask and input read gate are all 0xFFFF. The input sample and the status register are 0x0000, and `irq` is low.
- R2: `pin_oe` is the inverse of the direction register, because a direction bit of 1 makes the pin an input. `pin_out` carries the output latch bit on pins with direction 0 and 0 on input pins.
- R3: `pin_in` is sampled on every clock. An edge-polarity bit of 1 flags a 0-to-1 change of the sampled pin, and a bit of 0 flags a 1-to-0 change. A flagged change sets the pin's status bit at the clock edge that samples the new level.
- R4: A status bit is set only when the pin's direction bit is 1 and its mask bit is 0. A mask bit of 1, or a pin configured as an output, leaves the status bit unchanged.
- R5: A 16-bit write to offset 0x14 clears every status bit written as 1 and leaves the others unchanged. If a new edge on a bit arrives in the same cycle as a clear of that bit, the edge wins and the bit stays set.
- R6: `irq` is a registered OR of all status bits. It rises one clock after a status bit is set, and it falls one clock after the last status bit is cleared.
- R7: A 16-bit read of offset 0x00 returns the sampled inputs ANDed with the input read gate at offset 0x18.
- R8: A write to offset 0x00 changes no register.
- R9: An access whose `bus_size` is not 1 (16 bits) is rejected. Such a write changes no register, including the status register, and such a read returns 0.
- R10: An access to an offset outside 0x00–0x18, or to a misaligned offset, returns 0 on read and has no effect on write.
- R11: A 16-bit write to offset 0x04, 0x08, 0x0C, 0x10 or 0x18 loads the value at the next clock, and a later read of the same offset returns that value. A read of offset 0x14 returns the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_size | input | 2 | Access width: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational; 0 when there is no accepted read |
| pin_in | input | 16 | Pin levels, already synchronised |
| pin_oe | output | 16 | Per-pin output enable |
| pin_out | output | 16 | Per-pin output value |
| irq | output | 1 | Interrupt request |

## Verification
Some properties are checked on every cycle. `pin_out` never drives a bit on an input pin. A newly set status bit always follows a change of the sampled pin in the selected direction, on an unmasked input pin. An edge is never lost to a clear in the same cycle. `irq` rises and falls only against the status held one cycle earlier. A rejected-width write leaves every register stable, and a rejected-width read returns zero.

Some behaviour only the bench scenarios can show. These are:
- the reset contents;
- the exact register map;
- the read gate on the input register;
- that a write to the input offset, to an unmapped offset or to a misaligned offset is ignored;
- the clock-by-clock timing of status and `irq` when random pin activity runs against a reference model.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    // Width of the bus and of the pin bank.
    localparam int unsigned BANK_W = 16;

    // Access width codes carried on bus_size.
    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    // Register selection produced by the address decoder.
    typedef enum logic [2:0] {
        SEL_DIN  = 3'd0,
        SEL_DOUT = 3'd1,
        SEL_DIR  = 3'd2,
        SEL_EDGE = 3'd3,
        SEL_MASK = 3'd4,
        SEL_STAT = 3'd5,
        SEL_PCTL = 3'd6,
        SEL_NONE = 3'd7
    } reg_sel_e;

endpackage

// File: rtl/gpio_bank_decode.sv
module gpio_bank_decode
    import gpio_bank_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    output reg_sel_e          rsel,
    output logic              wr_en,
    output logic              rd_en
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] word_idx;
    logic             aligned;
    logic             width_ok;

    assign word_idx = bus_addr[ADDR_W-1:2];
    assign aligned  = (bus_addr[1:0] == 2'b00);
    assign width_ok = (bus_size == SZ_HALF);

    always_comb begin
        rsel = SEL_NONE;
        if (aligned) begin
            unique case (word_idx)
                IDX_W'(0): rsel = SEL_DIN;
                IDX_W'(1): rsel = SEL_DOUT;
                IDX_W'(2): rsel = SEL_DIR;
                IDX_W'(3): rsel = SEL_EDGE;
                IDX_W'(4): rsel = SEL_MASK;
                IDX_W'(5): rsel = SEL_STAT;
                IDX_W'(6): rsel = SEL_PCTL;
                default:   rsel = SEL_NONE;
            endcase
        end
    end

    assign wr_en = bus_sel & bus_wr & width_ok & (rsel != SEL_NONE) & (rsel != SEL_DIN);
    assign rd_en = bus_sel & ~bus_wr & width_ok & (rsel != SEL_NONE);

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter int DATA_W = BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  reg_sel_e          rsel,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] in_q,
    input  logic [DATA_W-1:0] status,
    output logic [DATA_W-1:0] out_q,
    output logic [DATA_W-1:0] dir_q,
    output logic [DATA_W-1:0] edge_q,
    output logic [DATA_W-1:0] mask_q,
    output logic [DATA_W-1:0] pctl_q,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] rd_mux;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q  <= '1;
            dir_q  <= '1;
            edge_q <= '1;
            mask_q <= '1;
            pctl_q <= '1;
        end else if (wr_en) begin
            unique case (rsel)
                SEL_DOUT: out_q  <= wdata;
                SEL_DIR:  dir_q  <= wdata;
                SEL_EDGE: edge_q <= wdata;
                SEL_MASK: mask_q <= wdata;
                SEL_PCTL: pctl_q <= wdata;
                default:  ;
            endcase
        end
    end

    always_comb begin
        rd_mux = '0;
        unique case (rsel)
            SEL_DIN:  rd_mux = in_q & pctl_q;
            SEL_DOUT: rd_mux = out_q;
            SEL_DIR:  rd_mux = dir_q;
            SEL_EDGE: rd_mux = edge_q;
            SEL_MASK: rd_mux = mask_q;
            SEL_STAT: rd_mux = status;
            SEL_PCTL: rd_mux = pctl_q;
            default:  rd_mux = '0;
        endcase
    end

    assign rdata = rd_en ? rd_mux : '0;

    // R11
    dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rsel == SEL_DIR) |=> (dir_q == $past(wdata)));

    // R8
    no_write_din_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsel == SEL_DIN) |=> ($stable(out_q) && $stable(pctl_q) && $stable(mask_q)));

endmodule

// File: rtl/gpio_bank_edge.sv
module gpio_bank_edge #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] pin_in,
    input  logic [DATA_W-1:0] dir_q,
    input  logic [DATA_W-1:0] edge_q,
    input  logic [DATA_W-1:0] mask_q,
    output logic [DATA_W-1:0] in_q,
    output logic [DATA_W-1:0] evt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) in_q <= '0;
        else        in_q <= pin_in;
    end

    for (genvar i = 0; i < DATA_W; i++) begin : g_pin
        logic rise;
        logic fall;
        assign rise   = pin_in[i] & ~in_q[i];
        assign fall   = ~pin_in[i] & in_q[i];
        assign evt[i] = (edge_q[i] ? rise : fall) & dir_q[i] & ~mask_q[i];
    end

endmodule

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] evt,
    input  logic [DATA_W-1:0] clr,
    output logic [DATA_W-1:0] status,
    output logic              irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status <= '0;
            irq    <= 1'b0;
        end else begin
            status <= (status & ~clr) | evt;
            irq    <= |status;
        end
    end

    // R5
    edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((status & $past(evt)) == $past(evt)));

    // R5
    clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr != '0) |=> ((status & $past(clr) & ~$past(evt)) == '0));

    // R6
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(status) != '0));

    // R6
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> ($past(status) == '0));

endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
    import gpio_bank_pkg::*;
#(
    parameter int DATA_W = BANK_W,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] pin_in,
    output logic [DATA_W-1:0] pin_oe,
    output logic [DATA_W-1:0] pin_out,
    output logic              irq
);
    reg_sel_e          rsel;
    logic              wr_en;
    logic              rd_en;
    logic [DATA_W-1:0] out_q, dir_q, edge_q, mask_q, pctl_q;
    logic [DATA_W-1:0] in_q, evt, clr, status;

    gpio_bank_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_size (bus_size),
        .rsel     (rsel),
        .wr_en    (wr_en),
        .rd_en    (rd_en)
    );

    gpio_bank_regs #(.DATA_W(DATA_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .rsel   (rsel),
        .wdata  (bus_wdata),
        .in_q   (in_q),
        .status (status),
        .out_q  (out_q),
        .dir_q  (dir_q),
        .edge_q (edge_q),
        .mask_q (mask_q),
        .pctl_q (pctl_q),
        .rdata  (bus_rdata)
    );

    gpio_bank_edge #(.DATA_W(DATA_W)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pin_in),
        .dir_q  (dir_q),
        .edge_q (edge_q),
        .mask_q (mask_q),
        .in_q   (in_q),
        .evt    (evt)
    );

    assign clr = (wr_en && rsel == SEL_STAT) ? bus_wdata : '0;

    gpio_bank_irq #(.DATA_W(DATA_W)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (evt),
        .clr    (clr),
        .status (status),
        .irq    (irq)
    );

    assign pin_oe  = ~dir_q;
    assign pin_out = out_q & ~dir_q;

    // R2
    no_drive_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out & ~pin_oe) == '0);

    // R3
    new_bit_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & ~$past(status)) &
         (~($past(pin_in) ^ $past(in_q)) | ($past(pin_in) ^ $past(edge_q)))) == '0);

    // R4
    masked_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & ~$past(status)) & ($past(mask_q) | ~$past(dir_q))) == '0);

    // R9
    bad_width_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_size != SZ_HALF) |=>
        ($stable(out_q) && $stable(dir_q) && $stable(edge_q) &&
         $stable(mask_q) && $stable(pctl_q)));

    // R9
    always_comb begin
        if (rst_n && bus_sel && !bus_wr && bus_size != SZ_HALF) begin
            bad_width_rd_chk: assert (bus_rdata == '0);
        end
    end

endmodule

// File: tb/sim_gpio_edge_bank.sv
`timescale 1ns/1ps
module sim_gpio_edge_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [1:0]  bus_size = 2'd1;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_oe;
    logic [15:0] pin_out;
    logic        irq;

    always #2.5 clk = ~clk;

    gpio_edge_bank u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_oe(pin_oe),
        .pin_out(pin_out), .irq(irq)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // reference model state
    logic [15:0] m_in, m_out, m_dir, m_edge, m_mask, m_stat, m_pctl;
    logic        m_irq;
    logic [15:0] cur_pins = '0;
    logic [15:0] last_rd;

    task automatic chk(input logic [15:0] got, input logic [15:0] exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [15:0] model_read(input logic [7:0] a, input logic [1:0] sz);
        if (sz != 2'd1) return 16'h0;
        case (a)
            8'h00: return m_in & m_pctl;
            8'h04: return m_out;
            8'h08: return m_dir;
            8'h0C: return m_edge;
            8'h10: return m_mask;
            8'h14: return m_stat;
            8'h18: return m_pctl;
            default: return 16'h0;
        endcase
    endfunction

    function automatic string tag_for(input logic [7:0] a, input logic [1:0] sz);
        if (sz != 2'd1) return "R9";
        case (a)
            8'h00: return "R7";
            8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18: return "R11";
            default: return "R10";
        endcase
    endfunction

    task automatic model_reset();
        m_in = '0; m_out = '1; m_dir = '1; m_edge = '1;
        m_mask = '1; m_stat = '0; m_pctl = '1; m_irq = 1'b0;
    endtask

    task automatic step(input logic sel, input logic wr, input logic [7:0] a,
                        input logic [1:0] sz, input logic [15:0] wd,
                        input logic [15:0] pins, input string tag);
        logic        ok_w;
        logic [15:0] evt, clr, n_stat;
        logic        n_irq;
        @(negedge clk);
        bus_sel = sel; bus_wr = wr; bus_addr = a; bus_size = sz;
        bus_wdata = wd; pin_in = pins; cur_pins = pins;
        #1;
        last_rd = bus_rdata;
        if (sel && !wr) chk(bus_rdata, model_read(a, sz), tag);
        else            chk(bus_rdata, 16'h0, "R11 idle rdata");
        chk({15'h0, irq}, {15'h0, m_irq}, "R6 irq");
        chk(pin_oe, ~m_dir, "R2 pin_oe");
        chk(pin_out, m_out & ~m_dir, "R2 pin_out");
        ok_w   = sel && wr && (sz == 2'd1);
        evt    = ((m_edge & pins & ~m_in) | (~m_edge & ~pins & m_in)) & m_dir & ~m_mask;
        clr    = (ok_w && a == 8'h14) ? wd : 16'h0;
        n_stat = (m_stat & ~clr) | evt;
        n_irq  = |m_stat;
        @(posedge clk);
        m_in = pins; m_stat = n_stat; m_irq = n_irq;
        if (ok_w) begin
            case (a)
                8'h04: m_out = wd;
                8'h08: m_dir = wd;
                8'h0C: m_edge = wd;
                8'h10: m_mask = wd;
                8'h18: m_pctl = wd;
                default: ;
            endcase
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [1:0] sz, input logic [15:0] wd);
        step(1'b1, 1'b1, a, sz, wd, cur_pins, "");
    endtask

    task automatic rd(input logic [7:0] a, input logic [1:0] sz, input logic [15:0] exp, input string tag);
        step(1'b1, 1'b0, a, sz, 16'h0, cur_pins, tag);
        chk(last_rd, exp, tag);
    endtask

    task automatic pins_to(input logic [15:0] p);
        step(1'b0, 1'b0, 8'h00, 2'd1, 16'h0, p, "");
    endtask

    initial begin
        #(5.0 * 200000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset contents
        rd(8'h00, 2'd1, 16'h0000, "R1 din");
        rd(8'h04, 2'd1, 16'hFFFF, "R1 dout");
        rd(8'h08, 2'd1, 16'hFFFF, "R1 dir");
        rd(8'h0C, 2'd1, 16'hFFFF, "R1 edge");
        rd(8'h10, 2'd1, 16'hFFFF, "R1 mask");
        rd(8'h14, 2'd1, 16'h0000, "R1 status");
        rd(8'h18, 2'd1, 16'hFFFF, "R1 pctl");
        chk({15'h0, irq}, 16'h0, "R1 irq");

        // configuration: low byte inputs, high byte outputs
        wr(8'h08, 2'd1, 16'h00FF);
        wr(8'h0C, 2'd1, 16'h000F);
        wr(8'h10, 2'd1, 16'h0000);
        wr(8'h04, 2'd1, 16'hA5A5);
        pins_to(16'h0000);
        chk(pin_oe, 16'hFF00, "R2 oe directed");
        chk(pin_out, 16'hA500, "R2 out directed");

        // R3 rising on pins 0-3
        pins_to(16'h000F);
        rd(8'h14, 2'd1, 16'h000F, "R3 rising");
        // R3 rising on falling-selected pins 4-7: no event
        pins_to(16'h00FF);
        rd(8'h14, 2'd1, 16'h000F, "R3 wrong polarity");
        pins_to(16'h000F);
        rd(8'h14, 2'd1, 16'h00FF, "R3 falling");
        // R4 output pins do not flag
        pins_to(16'hF00F);
        rd(8'h14, 2'd1, 16'h00FF, "R4 output pins");

        // R6 irq drops after clear
        wr(8'h14, 2'd1, 16'hFFFF);
        pins_to(16'hF00F);
        @(negedge clk); #1;
        chk({15'h0, irq}, 16'h0, "R6 irq cleared");

        // R4 masked pin
        wr(8'h10, 2'd1, 16'h0001);
        pins_to(16'h000E);
        pins_to(16'h000F);
        rd(8'h14, 2'd1, 16'h0000, "R4 masked");

        // R5 clear and edge together
        pins_to(16'h000D);
        step(1'b1, 1'b1, 8'h14, 2'd1, 16'h0002, 16'h000F, "");
        rd(8'h14, 2'd1, 16'h0002, "R5 edge wins");

        // R7 read gate
        wr(8'h18, 2'd1, 16'h000C);
        rd(8'h00, 2'd1, 16'h000C, "R7 gated din");

        // R8 write to input offset
        wr(8'h00, 2'd1, 16'hFFFF);
        rd(8'h00, 2'd1, 16'h000C, "R8 din unchanged");
        rd(8'h18, 2'd1, 16'h000C, "R8 pctl unchanged");

        // R9 bad widths
        wr(8'h08, 2'd0, 16'h1234);
        rd(8'h08, 2'd1, 16'h00FF, "R9 byte write");
        rd(8'h04, 2'd2, 16'h0000, "R9 word read");
        wr(8'h14, 2'd2, 16'hFFFF);
        rd(8'h14, 2'd1, 16'h0002, "R9 status kept");

        // R10 unmapped and misaligned
        wr(8'h1C, 2'd1, 16'h1111);
        wr(8'h06, 2'd1, 16'h0000);
        rd(8'h1C, 2'd1, 16'h0000, "R10 unmapped read");
        rd(8'h06, 2'd1, 16'h0000, "R10 misaligned read");
        rd(8'h04, 2'd1, 16'hA5A5, "R10 dout intact");

        // random traffic against the model
        for (int k = 0; k < 4000; k++) begin
            logic [7:0]  a;
            logic [1:0]  sz;
            logic [15:0] p;
            int op;
            a  = 8'(($urandom % 9) * 4);
            if (($urandom % 10) == 0) a = a | 8'(1 + $urandom % 3);
            sz = (($urandom % 8) == 0) ? 2'(($urandom % 2) * 2) : 2'd1;
            p  = cur_pins;
            if (($urandom % 3) == 0) p = p ^ 16'($urandom);
            op = $urandom % 4;
            if (op == 0)
                step(1'b1, 1'b1, a, sz, 16'($urandom), p, "");
            else if (op == 1)
                step(1'b1, 1'b0, a, sz, 16'h0, p, tag_for(a, sz));
            else
                step(1'b0, 1'b0, 8'h00, 2'd1, 16'h0, p, "");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule